// File: doc/BRIEF.md
# Zoned Asynchronous External Memory Controller

This controller turns single-word read and write requests from the chip's internal fabric into asynchronous cycles on an external memory bus. The external bus has 19 address bits, 16 data bits, separate active-low read and write strobes, four active-low chip-selects and a ready input. A three-bit zone field above the external address picks one of five zones: 0, 1, 2, 6 and 7. Each zone has its own lead, active and trail cycle counts. Each zone also has its own enable that lets the external ready input stretch the active phase.

An accepted request runs through four phases: lead, active, trail and a one-cycle completion. The chip-select of the zone stays low across lead, active and trail. The strobe is low only in the active phase. On writes the data bus is driven over the whole chip-select span. On reads, the data on the bus during the last active cycle is returned with the completion pulse. Zones 6 and 7 share one chip-select line. Zone numbers 3, 4 and 5 do not reach the bus. The controller handles one request at a time, and each pin output comes straight from a flop.

The data pins are split into an output, an output enable and an input so that the pad ring can build the tristate buffer.

Top module: `xbz_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, all four ext_cs_n bits are 1, ext_rd_n and ext_we_n are 1 and ext_data_oe is 0.
- R2: The zone field is req_addr[21:19]. Zone 0 drives ext_cs_n[0], zone 1 drives ext_cs_n[1], zone 2 drives ext_cs_n[2], and zones 6 and 7 both drive ext_cs_n[3]. At most one chip-select is low at a time. While it is low, ext_addr holds req_addr[18:0].
- R3: Configuration slot k holds the counts of one zone: slot 0 is zone 0, slot 1 is zone 1, slot 2 is zone 2, slot 3 is zone 6 and slot 4 is zone 7. The counts of slot k are cfg_setup[4k+3:4k], cfg_wait[4k+3:4k] and cfg_hold[4k+3:4k]. With ready not stretching, the chip-select is low for L+A+T consecutive cycles, where L, A and T are the lead, wait and hold counts. A count of 0 counts as 1.
- R4: The strobe is low only in the active phase. A read drives only ext_rd_n low and a write drives only ext_we_n low. A strobe is never low while all chip-selects are high.
- R5: During a write, ext_data_oe is 1 in exactly the chip-select-low cycles and ext_data_o equals req_wdata. During a read, ext_data_oe stays 0.
- R6: A read returns on rsp_rdata the value that ext_data_i held during the last active cycle. A write returns 0.
- R7: When cfg_rdy_en[k] is 1 and ext_ready is low in the first N active cycles, the active phase lasts max(A, N+1) cycles. When cfg_rdy_en[k] is 0, ext_ready has no effect and the active phase lasts A cycles.
- R8: req_ready is 0 from the cycle after acceptance until the cycle after completion. rsp_valid is a one-cycle pulse, and req_ready is 1 in the cycle after it.
- R9: A request to zone number 3, 4 or 5 drives no chip-select and no strobe. Its rsp_valid comes in the cycle after acceptance, with rsp_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Zone field [21:19] and external address [18:0] |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (0 for writes and unmapped zones) |
| cfg_setup | input | 20 | Lead count, 4 bits per slot |
| cfg_wait | input | 20 | Active count, 4 bits per slot |
| cfg_hold | input | 20 | Trail count, 4 bits per slot |
| cfg_rdy_en | input | 5 | Per-slot enable for ready stretching |
| ext_addr | output | 19 | External address |
| ext_data_o | output | 16 | External write data |
| ext_data_i | input | 16 | External read data |
| ext_data_oe | output | 1 | Drive enable for the data pads |
| ext_cs_n | output | 4 | Active-low chip-selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 1 | Active-low write strobe |
| ext_ready | input | 1 | External ready; low stretches the active phase |

## Verification
Properties check on every cycle that the chip-selects stay one-hot or idle, that a strobe never appears outside a chip-select or alongside the other strobe, and that the data drive is off whenever the read strobe is low. They also check that the address holds steady through an access, that a zone with stretching enabled stays active while ready is low, that a zero count gives a one-cycle phase, and that each completion is followed by idle. Only the directed scenarios can show the exact phase lengths for each zone's counts, the max(A, N+1) stretch against the same pattern with stretching disabled, the read value taken from the last active cycle rather than an earlier one, and the silent completion of unmapped zones.

// File: rtl/xbz_pkg.sv
package xbz_pkg;
  localparam int NSLOT  = 5;
  localparam int NCS    = 4;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_ACT   = 3'd2,
    PH_TRAIL = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

  // zone number served by each configuration slot
  function automatic int slot_zone(int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 6;
      default: return 7;
    endcase
  endfunction

  // chip-select line used by each slot; the last two slots share one
  function automatic int slot_cs(int s);
    return (s < NCS - 1) ? s : NCS - 1;
  endfunction
endpackage

// File: rtl/xbz_zone_decode.sv
module xbz_zone_decode
  import xbz_pkg::*;
#(
  parameter int ZB = 3
) (
  input  logic [ZB-1:0]     zone_num,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              mapped,
  output logic [NCS-1:0]    cs_vec
);
  logic [NSLOT-1:0] slot_hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_hit[s] = (zone_num == ZB'(slot_zone(s)));
  end

  always_comb begin
    slot_idx = '0;
    cs_vec   = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_hit[s]) begin
        slot_idx          = SLOT_W'(s);
        cs_vec[slot_cs(s)] = 1'b1;
      end
    end
  end

  assign mapped = |slot_hit;
endmodule

// File: rtl/xbz_phase_seq.sv
module xbz_phase_seq
  import xbz_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_mapped,
  input  logic [CW-1:0] len_setup,
  input  logic [CW-1:0] len_wait,
  input  logic [CW-1:0] len_hold,
  input  logic          rdy_en,
  input  logic          ext_ready,
  output phase_t        phase_q,
  output phase_t        phase_d,
  output logic          capture
);
  logic [CW-1:0] cnt_q, cnt_d, len_cur;
  logic          span_end;

  always_comb begin
    case (phase_q)
      PH_LEAD:  len_cur = len_setup;
      PH_ACT:   len_cur = len_wait;
      PH_TRAIL: len_cur = len_hold;
      default:  len_cur = '0;
    endcase
  end

  // cycle count within the phase has reached its length (0 acts as 1)
  assign span_end = (({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len_cur});

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (start) phase_d = start_mapped ? PH_LEAD : PH_DONE;
      PH_LEAD:  if (span_end) phase_d = PH_ACT;
      PH_ACT:   if (span_end && (!rdy_en || ext_ready)) phase_d = PH_TRAIL;
      PH_TRAIL: if (span_end) phase_d = PH_DONE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    if (phase_d != phase_q) cnt_d = '0;
    else if (&cnt_q)        cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign capture = (phase_q == PH_ACT) && (phase_d == PH_TRAIL);

  p_ready_stretch_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ACT && rdy_en && !ext_ready) |=> (phase_q == PH_ACT));

  p_zero_lead_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LEAD && len_setup == '0) |=> (phase_q == PH_ACT));
endmodule

// File: rtl/xbz_pin_reg.sv
module xbz_pin_reg
  import xbz_pkg::*;
#(
  parameter int XAW = 19,
  parameter int XDW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  phase_t         phase_d,
  input  logic [NCS-1:0] cs_d,
  input  logic           write_d,
  input  logic [XAW-1:0] addr_d,
  input  logic [XDW-1:0] wdata_d,
  output logic [XAW-1:0] ext_addr,
  output logic [XDW-1:0] ext_data_o,
  output logic           ext_data_oe,
  output logic [NCS-1:0] ext_cs_n,
  output logic           ext_rd_n,
  output logic           ext_we_n
);
  logic in_span, in_act;

  assign in_span = (phase_d == PH_LEAD) || (phase_d == PH_ACT) || (phase_d == PH_TRAIL);
  assign in_act  = (phase_d == PH_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr    <= '0;
      ext_data_o  <= '0;
      ext_data_oe <= 1'b0;
      ext_cs_n    <= '1;
      ext_rd_n    <= 1'b1;
      ext_we_n    <= 1'b1;
    end else begin
      ext_addr    <= addr_d;
      ext_data_o  <= wdata_d;
      ext_data_oe <= in_span && write_d;
      ext_cs_n    <= in_span ? ~cs_d : '1;
      ext_rd_n    <= !(in_act && !write_d);
      ext_we_n    <= !(in_act && write_d);
    end
  end
endmodule

// File: rtl/xbz_ctrl.sv
module xbz_ctrl
  import xbz_pkg::*;
#(
  parameter int XAW = 19,
  parameter int XDW = 16,
  parameter int CW  = 4,
  parameter int ZB  = 3,
  localparam int IAW = XAW + ZB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IAW-1:0]   req_addr,
  input  logic [XDW-1:0]   req_wdata,
  output logic             rsp_valid,
  output logic [XDW-1:0]   rsp_rdata,
  input  logic [NSLOT*CW-1:0] cfg_setup,
  input  logic [NSLOT*CW-1:0] cfg_wait,
  input  logic [NSLOT*CW-1:0] cfg_hold,
  input  logic [NSLOT-1:0] cfg_rdy_en,
  output logic [XAW-1:0]   ext_addr,
  output logic [XDW-1:0]   ext_data_o,
  input  logic [XDW-1:0]   ext_data_i,
  output logic             ext_data_oe,
  output logic [NCS-1:0]   ext_cs_n,
  output logic             ext_rd_n,
  output logic             ext_we_n,
  input  logic             ext_ready
);
  phase_t phase_q, phase_d;
  logic   start, capture, new_mapped;
  logic [SLOT_W-1:0] new_slot, slot_q, slot_d;
  logic [NCS-1:0]    new_cs, cs_q, cs_d;
  logic              write_q, write_d;
  logic [XAW-1:0]    addr_q, addr_d;
  logic [XDW-1:0]    wdata_q, wdata_d, rdata_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_DONE);
  assign rsp_rdata = rdata_q;
  assign start     = req_valid && req_ready;

  xbz_zone_decode #(.ZB(ZB)) dec_i (
    .zone_num (req_addr[IAW-1:XAW]),
    .slot_idx (new_slot),
    .mapped   (new_mapped),
    .cs_vec   (new_cs)
  );

  assign slot_d  = start ? new_slot            : slot_q;
  assign cs_d    = start ? new_cs              : cs_q;
  assign write_d = start ? req_write           : write_q;
  assign addr_d  = start ? req_addr[XAW-1:0]   : addr_q;
  assign wdata_d = start ? req_wdata           : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      cs_q    <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      slot_q  <= slot_d;
      cs_q    <= cs_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      if (start)                 rdata_q <= '0;
      else if (capture && !write_q) rdata_q <= ext_data_i;
    end
  end

  xbz_phase_seq #(.CW(CW)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_mapped (new_mapped),
    .len_setup    (cfg_setup[slot_q*CW +: CW]),
    .len_wait     (cfg_wait[slot_q*CW +: CW]),
    .len_hold     (cfg_hold[slot_q*CW +: CW]),
    .rdy_en       (cfg_rdy_en[slot_q]),
    .ext_ready    (ext_ready),
    .phase_q      (phase_q),
    .phase_d      (phase_d),
    .capture      (capture)
  );

  xbz_pin_reg #(.XAW(XAW), .XDW(XDW)) pins_i (
    .clk         (clk),
    .rst         (rst),
    .phase_d     (phase_d),
    .cs_d        (cs_d),
    .write_d     (write_d),
    .addr_d      (addr_d),
    .wdata_d     (wdata_d),
    .ext_addr    (ext_addr),
    .ext_data_o  (ext_data_o),
    .ext_data_oe (ext_data_oe),
    .ext_cs_n    (ext_cs_n),
    .ext_rd_n    (ext_rd_n),
    .ext_we_n    (ext_we_n)
  );

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!(&ext_cs_n) && $past(!(&ext_cs_n))) |-> $stable(ext_addr));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_we_n) |-> !(&ext_cs_n));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_we_n));

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> ext_rd_n);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&ext_cs_n && ext_rd_n && ext_we_n && !ext_data_oe));

  p_rsp_then_ready_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (req_ready && !rsp_valid));
endmodule

// File: tb/xbz_ctrl_tb_top.sv
module xbz_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] cfg_setup, cfg_wait, cfg_hold;
  logic [4:0]  cfg_rdy_en = 5'b01010;
  logic [18:0] ext_addr;
  logic [15:0] ext_data_o;
  logic [15:0] ext_data_i = '0;
  logic        ext_data_oe, ext_rd_n, ext_we_n;
  logic [3:0]  ext_cs_n;
  logic        ext_ready = 1'b1;

  logic [3:0] t_setup [5];
  logic [3:0] t_wait  [5];
  logic [3:0] t_hold  [5];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 5; i++) begin
      cfg_setup[i*4 +: 4] = t_setup[i];
      cfg_wait[i*4 +: 4]  = t_wait[i];
      cfg_hold[i*4 +: 4]  = t_hold[i];
    end
  end

  xbz_ctrl dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .cfg_rdy_en(cfg_rdy_en),
    .ext_addr(ext_addr), .ext_data_o(ext_data_o), .ext_data_i(ext_data_i),
    .ext_data_oe(ext_data_oe), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_ready(ext_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // one access with full per-cycle observation; nlow = active cycles with ready low
  task automatic do_access(input int zone, input bit wr, input logic [18:0] a,
                           input logic [15:0] wd, input int nlow);
    int slot, csi, l1, a1, t1, exp_act, exp_rd;
    int cs_cyc, st_cyc, oe_cyc, act_idx, bad_cs, bad_addr, bad_data, bad_strobe, busy_rdy, it;
    logic [15:0] last_rd;
    case (zone)
      0, 1, 2: slot = zone;
      6:       slot = 3;
      7:       slot = 4;
      default: slot = -1;
    endcase
    csi = (slot < 3) ? slot : 3;
    l1 = 0; a1 = 0; t1 = 0; exp_act = 0;
    if (slot >= 0) begin
      l1 = atleast1(int'(t_setup[slot]));
      a1 = atleast1(int'(t_wait[slot]));
      t1 = atleast1(int'(t_hold[slot]));
      exp_act = a1;
      if (cfg_rdy_en[slot] && nlow > 0 && nlow + 1 > a1) exp_act = nlow + 1;
    end
    cs_cyc = 0; st_cyc = 0; oe_cyc = 0; act_idx = 0; bad_cs = 0; bad_addr = 0;
    bad_data = 0; bad_strobe = 0; busy_rdy = 0; it = 0; last_rd = '0;

    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {3'(zone), a}; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && it < 400) begin
      it++;
      if (req_ready) busy_rdy++;
      if (!(&ext_cs_n)) begin
        cs_cyc++;
        if (slot < 0 || ext_cs_n != ~(4'b0001 << csi)) bad_cs++;
        if (ext_addr != a) bad_addr++;
      end
      if (ext_data_oe) begin
        oe_cyc++;
        if (ext_data_o != wd) bad_data++;
      end
      if (!ext_rd_n || !ext_we_n) begin
        st_cyc++;
        act_idx++;
        if (wr ? !ext_rd_n : !ext_we_n) bad_strobe++;
        if (!ext_rd_n) begin
          ext_data_i = 16'hA000 + 16'(act_idx);
          last_rd = ext_data_i;
        end
        ext_ready = (act_idx > nlow);
      end else begin
        ext_ready = 1'b1;
      end
      @(negedge clk);
    end
    ext_ready = 1'b1;
    exp_rd = (slot < 0 || wr) ? 0 : int'(16'hA000 + 16'(exp_act));
    chk(rsp_valid, "R8 completion seen", int'(rsp_valid), 1);
    chk(bad_cs == 0, "R2 chip-select line", bad_cs, 0);
    chk(bad_addr == 0, "R2 external address", bad_addr, 0);
    chk(cs_cyc == l1 + exp_act + t1, "R3 chip-select span", cs_cyc, l1 + exp_act + t1);
    chk(st_cyc == exp_act, "R7 active phase length", st_cyc, exp_act);
    chk(bad_strobe == 0, "R4 strobe kind", bad_strobe, 0);
    chk(oe_cyc == (wr ? cs_cyc : 0), "R5 drive cycles", oe_cyc, wr ? cs_cyc : 0);
    chk(bad_data == 0, "R5 write data", bad_data, 0);
    chk(int'(rsp_rdata) == exp_rd, "R6 returned data", int'(rsp_rdata), exp_rd);
    if (!wr && slot >= 0)
      chk(rsp_rdata == last_rd, "R6 last active sample", int'(rsp_rdata), int'(last_rd));
    chk(busy_rdy == 0, "R8 ready low while busy", busy_rdy, 0);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R8 idle after pulse", int'({req_ready, rsp_valid}), 2);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(ext_cs_n == 4'hF, "R1 chip-selects", int'(ext_cs_n), 15);
    chk(ext_rd_n && ext_we_n, "R1 strobes", int'({ext_rd_n, ext_we_n}), 3);
    chk(!ext_data_oe, "R1 data drive", int'(ext_data_oe), 0);
  endtask

  task automatic t_reads_all_zones();   // R2 R3 R4 R6
    do_access(0, 1'b0, 19'h0_1234, 16'h0, 0);
    do_access(1, 1'b0, 19'h7_FFFF, 16'h0, 0);
    do_access(2, 1'b0, 19'h0_0000, 16'h0, 0);
    do_access(6, 1'b0, 19'h2_AAAA, 16'h0, 0);
    do_access(7, 1'b0, 19'h5_5555, 16'h0, 0);
  endtask

  task automatic t_writes_all_zones();  // R5
    do_access(0, 1'b1, 19'h0_0042, 16'hBEEF, 0);
    do_access(2, 1'b1, 19'h1_0001, 16'h1357, 0);
    do_access(6, 1'b1, 19'h3_0F0F, 16'hFFFF, 0);
    do_access(7, 1'b1, 19'h4_0000, 16'h0001, 0);
  endtask

  task automatic t_zero_counts();       // R3: slot 1 has all counts 0
    do_access(1, 1'b1, 19'h0_00AA, 16'h5A5A, 0);
    do_access(1, 1'b0, 19'h0_00AB, 16'h0, 0);
  endtask

  task automatic t_ready_stretch();     // R7: zone 6 honours ready
    do_access(6, 1'b0, 19'h0_0100, 16'h0, 5);
    do_access(6, 1'b0, 19'h0_0101, 16'h0, 1);
    do_access(6, 1'b1, 19'h0_0102, 16'hC0DE, 8);
  endtask

  task automatic t_ready_ignored();     // R7: zone 7 ignores ready
    do_access(7, 1'b0, 19'h0_0200, 16'h0, 6);
    do_access(0, 1'b0, 19'h0_0201, 16'h0, 9);
  endtask

  task automatic t_unmapped();          // R9
    do_access(3, 1'b0, 19'h0_0300, 16'h0, 0);
    do_access(4, 1'b1, 19'h0_0301, 16'hAAAA, 0);
    do_access(5, 1'b0, 19'h0_0302, 16'h0, 0);
  endtask

  task automatic t_long_counts();       // R3 at full count
    t_setup[0] = 4'd15; t_wait[0] = 4'd15; t_hold[0] = 4'd15;
    do_access(0, 1'b0, 19'h6_0000, 16'h0, 0);
    t_setup[0] = 4'd1; t_wait[0] = 4'd2; t_hold[0] = 4'd1;
  endtask

  initial begin
    t_setup[0] = 4'd1; t_wait[0] = 4'd2; t_hold[0] = 4'd1;
    t_setup[1] = 4'd0; t_wait[1] = 4'd0; t_hold[1] = 4'd0;
    t_setup[2] = 4'd3; t_wait[2] = 4'd1; t_hold[2] = 4'd2;
    t_setup[3] = 4'd2; t_wait[3] = 4'd3; t_hold[3] = 4'd0;
    t_setup[4] = 4'd1; t_wait[4] = 4'd4; t_hold[4] = 4'd3;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reads_all_zones();
    t_writes_all_zones();
    t_zero_counts();
    t_ready_stretch();
    t_ready_ignored();
    t_unmapped();
    t_long_counts();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
  end
endmodule